// File: doc/BRIEF.md
# Camera Sensor Register Bus Master

This block runs single-register transactions on the two-wire serial bus that image sensors use for configuration. A host presents a command (device identifier, register sub-address, write data and a read/write select) and pulses `cmd_valid`. The block then drives the bus clock and the open-drain data line until the transaction ends with a stop condition. It reports `busy` while it works and a one-cycle `done` pulse at the end. An acknowledge error flag and the received byte stay valid afterwards.

A write puts three bytes on the bus: the write identifier, the sub-address and the data. A read has two phases. The first sends the write identifier and the sub-address and ends with a stop. The second opens with a new start, sends the read identifier, receives one byte and answers it with a not-acknowledge. The data line is never driven high: a one is produced by releasing the output enable. The bus clock runs at a programmable rate, with every bit split into four quarter periods of `clk_div+1` clock cycles each.

Top module: `cam_reg_master`

## Requirements
- R1: After reset and whenever `busy` is low, `scl_o` is 1 and `sda_oe` is 0, and `busy`, `done` and `ack_err` are 0 after reset.
- R2: Each bus phase opens with a start condition (data falls while the clock is high) and closes with a stop condition (data rises while the clock is high).
- R3: Apart from start and stop conditions, the data line changes only while the clock is low.
- R4: A write sends `cmd_dev_id` with bit 0 forced to 0, then `cmd_sub_addr`, then `cmd_wdata`. Each byte goes most significant bit first and is followed by a ninth clock during which the master releases the line for the acknowledge.
- R5: A read sends the write identifier and the sub-address, then a stop, then a new start and `cmd_dev_id` with bit 0 forced to 1. It then clocks in 8 bits, most significant first, answers with a released (high) ninth bit and stops. The received byte appears on `rd_data` when `done` pulses.
- R6: If the line is high during the acknowledge clock of any byte the master sends, the transaction skips all remaining bytes and phases, issues a stop, and `ack_err` is 1 from the `done` pulse onward.
- R7: During every data or acknowledge bit, `scl_o` stays high for exactly 2*(`clk_div`+1) clock cycles.
- R8: `busy` rises in the cycle after a command is accepted (`cmd_valid` high while `busy` is low). `done` is a single-cycle pulse, asserted when `busy` falls. A `cmd_valid` seen while `busy` is high has no effect.
- R9: `ack_err` clears in the cycle after the next command is accepted. `rd_data` changes only when a read receives its data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a transaction with the command fields below |
| cmd_read | input | 1 | 1 selects a register read, 0 a register write |
| cmd_dev_id | input | 8 | Device identifier; bit 0 is replaced by the direction |
| cmd_sub_addr | input | 8 | Register sub-address |
| cmd_wdata | input | 8 | Data byte for a write |
| clk_div | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| ack_err | output | 1 | Last transaction lost an acknowledge |
| rd_data | output | 8 | Byte received by the last successful read |
| scl_o | output | 1 | Bus clock |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sensed level of the data line |

## Verification
On every cycle, the bound checker watches the bus-level rules. The data line must hold while the clock is high unless a start or stop is being formed, and it may be pulled low with the clock high only as part of a start. The bus must be released whenever the block is idle. The checker also covers the handshake around `busy` and `done`, and the point at which `ack_err` is set and cleared. The byte order, the bit order within each byte, the repeated start of a read, early termination after a missing acknowledge and the clock high time can only be shown by the bench: a sensor model on the wired-AND line decodes every bus event and compares it with the sequence that the driver queued for each command.

// File: rtl/cam_reg_pkg.sv
`timescale 1ns/1ps
package cam_reg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_STOP  = 2'd1,
    BOP_BIT   = 2'd2
  } bit_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_BITS  = 2'd2,
    SQ_STOP  = 2'd3
  } seq_st_e;

  // Identifier with the direction bit cleared (write) or set (read).
  function automatic logic [BYTE_W-1:0] wr_ident(input logic [BYTE_W-1:0] id);
    return id & 8'hFE;
  endfunction

  function automatic logic [BYTE_W-1:0] rd_ident(input logic [BYTE_W-1:0] id);
    return id | 8'h01;
  endfunction

  // Number of bytes the master itself transmits in one bus phase.
  function automatic logic [1:0] tx_bytes(input logic is_rd, input logic second_phase);
    if (!is_rd)            return 2'd3;
    else if (!second_phase) return 2'd2;
    else                   return 2'd1;
  endfunction

  // Byte to transmit at a given position of the current phase.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic second_phase,
                                                  input logic [1:0] idx,
                                                  input logic [BYTE_W-1:0] dev,
                                                  input logic [BYTE_W-1:0] sub,
                                                  input logic [BYTE_W-1:0] wd);
    if (second_phase) return rd_ident(dev);
    case (idx)
      2'd0:    return wr_ident(dev);
      2'd1:    return sub;
      default: return wd;
    endcase
  endfunction

  // Bit sent at position idx, most significant first.
  function automatic logic msb_bit(input logic [BYTE_W-1:0] b, input logic [2:0] idx);
    return b[3'd7 - idx];
  endfunction

endpackage

// File: rtl/crm_tick_gen.sv
`timescale 1ns/1ps
module crm_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/crm_bit_phy.sv
`timescale 1ns/1ps
module crm_bit_phy
  import cam_reg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    op_valid,
  input  bit_op_e op,
  input  logic    op_bit,
  input  logic    sda_i,
  output logic    op_ready,
  output logic    op_done,
  output logic    rx_bit,
  output logic    scl_o,
  output logic    sda_oe,
  output logic    cond_active
);
  logic    active_q;
  bit_op_e op_q;
  logic    bit_q;
  logic [1:0] ph_q;

  assign op_ready    = !active_q;
  assign cond_active = active_q && (op_q != BOP_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      op_q     <= BOP_START;
      bit_q    <= 1'b1;
      ph_q     <= 2'd0;
      scl_o    <= 1'b1;
      sda_oe   <= 1'b0;
      rx_bit   <= 1'b1;
      op_done  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (!active_q) begin
        if (op_valid) begin
          active_q <= 1'b1;
          op_q     <= op;
          bit_q    <= op_bit;
          ph_q     <= 2'd0;
        end
      end else if (tick) begin
        case (op_q)
          BOP_START: begin
            case (ph_q)
              2'd0:    begin scl_o <= 1'b1; sda_oe <= 1'b0; end
              2'd1:    sda_oe <= 1'b1;
              2'd2:    scl_o  <= 1'b0;
              default: ;
            endcase
          end
          BOP_STOP: begin
            case (ph_q)
              2'd0:    begin scl_o <= 1'b0; sda_oe <= 1'b1; end
              2'd1:    scl_o  <= 1'b1;
              2'd2:    sda_oe <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (ph_q)
              2'd0:    begin scl_o <= 1'b0; sda_oe <= !bit_q; end
              2'd1:    scl_o  <= 1'b1;
              2'd2:    rx_bit <= sda_i;
              default: scl_o  <= 1'b0;
            endcase
          end
        endcase
        ph_q <= ph_q + 2'd1;
        if (ph_q == 2'd3) begin
          active_q <= 1'b0;
          op_done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cam_reg_master.sv
`timescale 1ns/1ps
module cam_reg_master
  import cam_reg_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [BYTE_W-1:0] cmd_dev_id,
  input  logic [BYTE_W-1:0] cmd_sub_addr,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              busy,
  output logic              done,
  output logic              ack_err,
  output logic [BYTE_W-1:0] rd_data,
  output logic              scl_o,
  output logic              sda_oe,
  input  logic              sda_i
);
  localparam int unsigned IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_SLOT = IDX_W'(BYTE_W);

  seq_st_e st_q;
  logic is_rd_q, ph2_q, rx_mode_q, err_q, wait_q;
  logic [BYTE_W-1:0] dev_q, sub_q, wd_q, shreg_q;
  logic [1:0] byte_idx_q;
  logic [IDX_W-1:0] bit_idx_q;
  logic [DIV_W-1:0] div_q;

  // Named internal events
  logic tick, phy_ready, phy_done, phy_rx, phy_cond_active;
  logic op_valid, op_bit, ack_slot, last_tx, accept;
  bit_op_e op_sel;
  logic [BYTE_W-1:0] cur_byte;

  assign busy     = (st_q != SQ_IDLE);
  assign accept   = cmd_valid && !busy;
  assign cur_byte = pick_byte(ph2_q, byte_idx_q, dev_q, sub_q, wd_q);
  assign ack_slot = (bit_idx_q == ACK_SLOT);
  assign last_tx  = ((byte_idx_q + 2'd1) == tx_bytes(is_rd_q, ph2_q));
  assign op_valid = busy && !wait_q && phy_ready;

  always_comb begin
    op_sel = BOP_BIT;
    op_bit = 1'b1;
    case (st_q)
      SQ_START: op_sel = BOP_START;
      SQ_STOP:  op_sel = BOP_STOP;
      SQ_BITS:  op_bit = (rx_mode_q || ack_slot) ? 1'b1 : msb_bit(cur_byte, bit_idx_q[2:0]);
      default:  ;
    endcase
  end

  crm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  crm_bit_phy u_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .op_valid   (op_valid),
    .op         (op_sel),
    .op_bit     (op_bit),
    .sda_i      (sda_i),
    .op_ready   (phy_ready),
    .op_done    (phy_done),
    .rx_bit     (phy_rx),
    .scl_o      (scl_o),
    .sda_oe     (sda_oe),
    .cond_active(phy_cond_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      is_rd_q    <= 1'b0;
      ph2_q      <= 1'b0;
      rx_mode_q  <= 1'b0;
      err_q      <= 1'b0;
      wait_q     <= 1'b0;
      dev_q      <= '0;
      sub_q      <= '0;
      wd_q       <= '0;
      shreg_q    <= '0;
      byte_idx_q <= 2'd0;
      bit_idx_q  <= '0;
      div_q      <= '0;
      done       <= 1'b0;
      ack_err    <= 1'b0;
      rd_data    <= '0;
    end else begin
      done <= 1'b0;
      if (op_valid) wait_q <= 1'b1;
      case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            is_rd_q <= cmd_read;
            dev_q   <= cmd_dev_id;
            sub_q   <= cmd_sub_addr;
            wd_q    <= cmd_wdata;
            div_q   <= clk_div;
            ph2_q   <= 1'b0;
            err_q   <= 1'b0;
            ack_err <= 1'b0;
            st_q    <= SQ_START;
          end
        end
        SQ_START: begin
          if (phy_done) begin
            wait_q     <= 1'b0;
            st_q       <= SQ_BITS;
            bit_idx_q  <= '0;
            byte_idx_q <= 2'd0;
            rx_mode_q  <= 1'b0;
          end
        end
        SQ_BITS: begin
          if (phy_done) begin
            wait_q <= 1'b0;
            if (!ack_slot) begin
              if (rx_mode_q) shreg_q <= {shreg_q[BYTE_W-2:0], phy_rx};
              bit_idx_q <= bit_idx_q + IDX_W'(1);
            end else if (rx_mode_q) begin
              rd_data <= shreg_q;
              st_q    <= SQ_STOP;
            end else if (phy_rx) begin
              err_q <= 1'b1;
              st_q  <= SQ_STOP;
            end else if (last_tx) begin
              if (is_rd_q && ph2_q) begin
                rx_mode_q <= 1'b1;
                bit_idx_q <= '0;
              end else begin
                st_q <= SQ_STOP;
              end
            end else begin
              byte_idx_q <= byte_idx_q + 2'd1;
              bit_idx_q  <= '0;
            end
          end
        end
        default: begin
          if (phy_done) begin
            wait_q <= 1'b0;
            if (is_rd_q && !ph2_q && !err_q) begin
              ph2_q <= 1'b1;
              st_q  <= SQ_START;
            end else begin
              st_q    <= SQ_IDLE;
              done    <= 1'b1;
              ack_err <= err_q;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cam_reg_master_chk.sv
`timescale 1ns/1ps
module cam_reg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic ack_err,
  input logic scl_o,
  input logic sda_oe,
  input logic cond_active
);
  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe)); // R1

  AST_LOW_PULL_ONLY_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && scl_o) |-> $past(cond_active)); // R2

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && !$past(cond_active)) |-> $stable(sda_oe)); // R3

  AST_ERR_SET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_err) |-> done); // R6

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy); // R8

  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_ERR_CLEARED_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> !ack_err); // R9
endmodule

bind cam_reg_master cam_reg_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .busy       (busy),
  .done       (done),
  .ack_err    (ack_err),
  .scl_o      (scl_o),
  .sda_oe     (sda_oe),
  .cond_active(phy_cond_active)
);

// File: tb/cam_reg_master_tb_top.sv
`timescale 1ns/1ps
module cam_reg_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [7:0] cmd_dev_id = 8'h00, cmd_sub_addr = 8'h00, cmd_wdata = 8'h00;
  logic [15:0] clk_div = 16'd0;
  logic busy, done, ack_err, scl_o, sda_oe;
  logic [7:0] rd_data;
  logic slave_low = 1'b0;
  wire  sda_line = !(sda_oe || slave_low);

  always #2 clk = ~clk;

  cam_reg_master #(.DIV_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_dev_id(cmd_dev_id), .cmd_sub_addr(cmd_sub_addr), .cmd_wdata(cmd_wdata),
    .clk_div(clk_div), .busy(busy), .done(done), .ack_err(ack_err),
    .rd_data(rd_data), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  // Scoreboard: token = {kind[3:0], value[7:0], ack}; kind 1 start, 2 stop, 3 byte
  logic [12:0] exp_q[$];
  int n_tests = 0, n_fail = 0;  // driver side
  int m_tests = 0, m_fail = 0;  // monitor side
  int cur_div = 0, nack_at = -1, cmd_id = 0;
  logic [7:0] rd_val = 8'h00;

  function automatic logic [12:0] tok(input int kind, input logic [7:0] v, input logic a);
    return {kind[3:0], v, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input string what, input int act, input int expv);
    m_tests++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic observe(input logic [12:0] t);
    logic [12:0] e;
    if (exp_q.size() == 0) mchk(1'b0, "R2 R4 R5 R6", "unexpected bus event", int'(t), 0);
    else begin
      e = exp_q.pop_front();
      mchk(t == e, "R2 R4 R5 R6", "bus event", int'(t), int'(e));
    end
  endtask

  // Sensor model and bus monitor on the wired-AND line
  logic p_scl = 1'b1, p_sda = 1'b1, rise_ok = 1'b0, slave_tx = 1'b0, first = 1'b0;
  int bitcnt = 0, byte_ctr = 0, seen_id = -1;
  logic [7:0] shift = 8'h00;
  time t_rise = 0;

  always @(scl_o or sda_line) begin
    if (rst_n !== 1'b1) begin
      p_scl = scl_o;
    end else if (scl_o !== p_scl) begin
      p_scl = scl_o;
      if (scl_o) begin
        t_rise = $time;
        rise_ok = 1'b1;
        if (bitcnt < 8) shift = {shift[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 9) begin
          observe(tok(3, shift, sda_line));
          bitcnt = 0;
          byte_ctr++;
          if (slave_tx) slave_tx = 1'b0;
          else if (first && shift[0]) slave_tx = 1'b1;
          first = 1'b0;
        end
      end else begin
        if (rise_ok) mchk(int'($time - t_rise) == 2*(cur_div+1)*4, "R7", "scl high time",
                          int'($time - t_rise), 2*(cur_div+1)*4);
        rise_ok = 1'b0;
        if (bitcnt == 8 && !slave_tx) slave_low = (byte_ctr != nack_at);
        else if (slave_tx && bitcnt < 8) slave_low = !rd_val[7-bitcnt];
        else slave_low = 1'b0;
      end
    end else if (sda_line !== p_sda && scl_o === 1'b1) begin
      if (!sda_line) begin
        if (seen_id != cmd_id) begin seen_id = cmd_id; byte_ctr = 0; end
        observe(tok(1, 8'h00, 1'b0));
        bitcnt = 0; first = 1'b1; slave_tx = 1'b0; rise_ok = 1'b0;
      end else begin
        observe(tok(2, 8'h00, 1'b0));
        bitcnt = 0; slave_tx = 1'b0; rise_ok = 1'b0;
      end
    end
    p_sda = sda_line;
  end

  // Driver: queue expected events, issue the command, check the outcome
  task automatic run_cmd(input bit rd, input logic [7:0] dev, input logic [7:0] sub,
                         input logic [7:0] wd, input int div, input int nk,
                         input logic [7:0] rv, input bit poke);
    logic [7:0] prev_rd;
    bit ended, got;
    int t;
    cur_div = div; nack_at = nk; rd_val = rv; cmd_id++;
    ended = 1'b0;
    exp_q.push_back(tok(1, 8'h00, 1'b0));
    if (!rd) begin
      for (int k = 0; k < 3; k++) begin
        if (!ended) begin
          exp_q.push_back(tok(3, (k == 0) ? (dev & 8'hFE) : ((k == 1) ? sub : wd), k == nk));
          if (k == nk) ended = 1'b1;
        end
      end
      exp_q.push_back(tok(2, 8'h00, 1'b0));
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (!ended) begin
          exp_q.push_back(tok(3, (k == 0) ? (dev & 8'hFE) : sub, k == nk));
          if (k == nk) ended = 1'b1;
        end
      end
      exp_q.push_back(tok(2, 8'h00, 1'b0));
      if (!ended) begin
        exp_q.push_back(tok(1, 8'h00, 1'b0));
        exp_q.push_back(tok(3, dev | 8'h01, nk == 2));
        if (nk != 2) exp_q.push_back(tok(3, rv, 1'b1));
        exp_q.push_back(tok(2, 8'h00, 1'b0));
      end
    end
    prev_rd = rd_data;
    @(negedge clk);
    cmd_read = rd; cmd_dev_id = dev; cmd_sub_addr = sub; cmd_wdata = wd;
    clk_div = 16'(div); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
    chk(ack_err == 1'b0, "R9", "ack_err cleared on accept", int'(ack_err), 0);
    got = 1'b0; t = 0;
    while (!got && t < 40000) begin
      @(negedge clk);
      t++;
      if (poke && t == 40) begin
        cmd_valid = 1'b1; cmd_read = !rd; cmd_sub_addr = ~sub; cmd_wdata = ~wd;
      end else cmd_valid = 1'b0;
      if (done) got = 1'b1;
    end
    cmd_valid = 1'b0;
    chk(got, "R8", "done pulse seen", int'(got), 1);
    chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
    chk(ack_err == (nk >= 0), "R6", "ack_err at done", int'(ack_err), int'(nk >= 0));
    if (rd && nk < 0) chk(rd_data == rv, "R5", "read data", int'(rd_data), int'(rv));
    else chk(rd_data == prev_rd, "R9", "rd_data held", int'(rd_data), int'(prev_rd));
    chk(exp_q.size() == 0, "R4", "all queued bus events seen", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", int'(done), 0);
    chk(scl_o && !sda_oe, "R1", "bus released when idle", int'({scl_o, sda_oe}), 2);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #800000;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + m_tests + 1, n_fail + m_fail + 1);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    chk(scl_o == 1'b1 && sda_oe == 1'b0, "R1", "bus in reset", int'({scl_o, sda_oe}), 2);
    chk(!busy && !done && !ack_err, "R1", "flags in reset", int'({busy, done, ack_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl_o == 1'b1 && sda_oe == 1'b0 && !busy, "R1", "idle after reset", int'({scl_o, sda_oe, busy}), 4);
    // write, typical sensor setup value
    run_cmd(1'b0, 8'h42, 8'h13, 8'h07, 3, -1, 8'h00, 1'b0);
    // read with repeated start (R5)
    run_cmd(1'b1, 8'h42, 8'h0A, 8'h00, 1, -1, 8'h76, 1'b0);
    // alternating patterns at the fastest rate (R4, R7)
    run_cmd(1'b0, 8'h42, 8'h5A, 8'hA5, 0, -1, 8'h00, 1'b0);
    // direction bit forced to 0 on a write (R4)
    run_cmd(1'b0, 8'h43, 8'hFF, 8'h00, 2, -1, 8'h00, 1'b0);
    // device absent: no ack on the identifier (R6)
    run_cmd(1'b0, 8'h42, 8'h14, 8'h00, 1, 0, 8'h00, 1'b0);
    // data byte refused (R6)
    run_cmd(1'b0, 8'h42, 8'h28, 8'h60, 1, 2, 8'h00, 1'b0);
    // read with the read identifier refused: rd_data held (R6, R9)
    run_cmd(1'b1, 8'h42, 8'h1C, 8'h00, 1, 2, 8'hC3, 1'b0);
    // read with sub-address refused: no second phase (R6)
    run_cmd(1'b1, 8'h42, 8'h1D, 8'h00, 0, 1, 8'hC3, 1'b0);
    // read of all ones while a second command is attempted mid-way (R8)
    run_cmd(1'b1, 8'h42, 8'h11, 8'h00, 2, -1, 8'hFF, 1'b1);
    // read of all zeros, write poked mid-way (R5, R8)
    run_cmd(1'b1, 8'h42, 8'h12, 8'h00, 0, -1, 8'h00, 1'b1);
    // write with a longer bit time (R7)
    run_cmd(1'b0, 8'h42, 8'h17, 8'h3C, 9, -1, 8'h00, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests + m_tests, n_fail + m_fail);
    $finish;
  end
endmodule